// File: doc/BRIEF.md
# Double-Buffered Clock Controller Configuration Registers

This block is the byte-wide configuration store of a clock-generation controller. A serial host front end, which is not part of this block, turns bus transactions into a simple parallel register access made of an address, write data and a write strobe. The block answers that access with registered read data. It holds the settings that the host programs and drives them to the loop, the phase aligner and the output stage.

Three of the loop settings and the phase aligner setting are double-buffered. A host write lands only in a shadow copy. The working copy that feeds the datapath changes only when the host writes a command byte to the command address. Inside that byte, the high nibble selects a loop commit and the low nibble selects an aligner commit. Each commit also produces a single-cycle reset pulse for its subsystem, so a new divider or resolution and the restart of the subsystem take effect in the same cycle. The block also serves two fixed identification bytes and a status byte that shows the two lock inputs live.

Top module: `cfg_shadow_regs`

## Requirements
- R1: After a synchronous reset, the registers at addresses 0x0 to 0x7 read back 0x41, 0x00, 0xFF, 0x0F, 0x80, 0x03, 0x1F, 0x80 in address order. The working copies also hold the values of their registers: loop control 0x00, feedback divider 0xFFF, aligner control 0x03. Both pulse outputs are low and `rd_data` is 0x00.
- R2: A write to an address from 0x0 to 0x7 stores the byte, and a later read returns it with the reserved bits forced to zero. The keep masks are 0x37 for address 0x1, 0x0F for address 0x3 and 0xBF for address 0x4. All other writable addresses keep every bit.
- R3: The registers at addresses 0x0, 0x4, 0x6 and 0x7 drive `in_ctrl`, `phase_ofs`, `out_en` and `osc_div`. Each output shows a new value in the cycle after the write edge.
- R4: Writes to addresses 0x1, 0x2, 0x3 and 0x5 leave `loop_ctl_wk`, `fb_div_wk` and `align_ctl_wk` unchanged until a matching commit.
- R5: A write to address 0x8 whose bits 7:4 equal 0x5 copies shadows 0x1, 0x2 and 0x3 into the loop working copies. It also raises `loop_rst_pulse` for exactly the cycle after the write edge.
- R6: A write to address 0x8 whose bits 3:0 equal 0xA copies shadow 0x5 into `align_ctl_wk`. It also raises `align_rst_pulse` for exactly the cycle after the write edge. The byte 0x5A performs both commits in the same cycle.
- R7: A write to address 0x8 whose nibbles do not match performs neither commit and raises no pulse. This includes the swapped byte 0xA5.
- R8: Address 0x10 reads 0x18 and address 0x11 reads 0x01. Address 0x8 reads 0x00.
- R9: Address 0x12 reads the aligner lock input in bit 0 and the loop lock input in bit 1, both as sampled at the read edge. Bits 7:2 read zero.
- R10: Any other address reads 0x00. Writes to addresses 0x10 to 0x12 and to unmapped addresses change no register and no output.
- R11: `rd_data` is registered. After each clock edge it holds the contents of the address presented at that edge, taken before any write at the same edge.
- R12: `fb_div_wk` is 12 bits wide. Its bits 7:0 come from the working copy of address 0x2 and its bits 11:8 from the low nibble of the working copy of address 0x3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 5 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe, one write per cycle |
| aligner_lock | input | 1 | Live lock flag from the phase aligner |
| loop_lock | input | 1 | Live lock flag from the loop |
| rd_data | output | 8 | Registered read data |
| in_ctrl | output | 8 | Input control setting (address 0x0) |
| phase_ofs | output | 8 | Aligner offset and filter select (address 0x4) |
| out_en | output | 8 | Output enables and scaler (address 0x6) |
| osc_div | output | 8 | Oscillator divider setting (address 0x7) |
| loop_ctl_wk | output | 8 | Working copy of loop control (address 0x1) |
| fb_div_wk | output | 12 | Working feedback divider |
| align_ctl_wk | output | 8 | Working copy of aligner control (address 0x5) |
| loop_rst_pulse | output | 1 | One-cycle loop reset |
| align_rst_pulse | output | 1 | One-cycle aligner reset |

## Verification
The hardest state to reach from the ports has shadow and working copies that differ, followed by a command byte that matches only one nibble. The stimulus therefore first reprograms every double-buffered shadow with a distinct value. It then issues 0x50, 0x0A, 0xA5 and 0x5A in turn, and a stretch of pseudo-random traffic follows that mixes command bytes into register writes. The bench shows that a partial commit leaves the other working copy on its old value. It also shows that back-to-back commands hold a pulse high across consecutive cycles.

// File: rtl/cfg_regs_pkg.sv
package cfg_regs_pkg;

  localparam int DATA_W   = 8;
  localparam int ADDR_W   = 5;
  localparam int NUM_RW   = 8;
  localparam int IDX_W    = $clog2(NUM_RW);
  localparam int FB_W     = 12;
  localparam int NIB_W    = DATA_W / 2;

  localparam logic [ADDR_W-1:0] A_LOOP_CTL = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_FB_LO    = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_FB_HI    = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_ALIGN    = ADDR_W'(5);
  localparam logic [ADDR_W-1:0] A_CMD      = ADDR_W'(8);
  localparam logic [ADDR_W-1:0] A_ID_VER   = ADDR_W'(16);
  localparam logic [ADDR_W-1:0] A_ID_REV   = ADDR_W'(17);
  localparam logic [ADDR_W-1:0] A_STATUS   = ADDR_W'(18);

  localparam logic [DATA_W-1:0] ID_VER_VAL = 8'h18;
  localparam logic [DATA_W-1:0] ID_REV_VAL = 8'h01;

  localparam logic [NIB_W-1:0] CMD_LOOP_NIB  = 4'h5;
  localparam logic [NIB_W-1:0] CMD_ALIGN_NIB = 4'hA;

  typedef logic [NUM_RW-1:0][DATA_W-1:0] rw_bank_t;

  function automatic logic [DATA_W-1:0] rw_reset(input int idx);
    case (idx)
      0:       return 8'h41;
      1:       return 8'h00;
      2:       return 8'hFF;
      3:       return 8'h0F;
      4:       return 8'h80;
      5:       return 8'h03;
      6:       return 8'h1F;
      default: return 8'h80;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] rw_keep(input int idx);
    case (idx)
      1:       return 8'h37;
      3:       return 8'h0F;
      4:       return 8'hBF;
      default: return 8'hFF;
    endcase
  endfunction

endpackage

// File: rtl/cfg_host_regs.sv
module cfg_host_regs
  import cfg_regs_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  output rw_bank_t          shadow
);

  for (genvar gi = 0; gi < NUM_RW; gi++) begin : g_reg
    localparam logic [DATA_W-1:0] RST_V = rw_reset(gi);
    localparam logic [DATA_W-1:0] KEEP  = rw_keep(gi);
    logic hit;
    assign hit = bus_we && (bus_addr == ADDR_W'(gi));

    always_ff @(posedge clk) begin
      if (rst)
        shadow[gi] <= RST_V;
      else if (hit)
        shadow[gi] <= bus_wdata & KEEP;
    end
  end

endmodule

// File: rtl/cfg_commit.sv
module cfg_commit
  import cfg_regs_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] sh_loop,
  input  logic [DATA_W-1:0] sh_fb_lo,
  input  logic [FB_W-DATA_W-1:0] sh_fb_hi,
  input  logic [DATA_W-1:0] sh_align,
  output logic [DATA_W-1:0] loop_ctl_wk,
  output logic [FB_W-1:0]   fb_div_wk,
  output logic [DATA_W-1:0] align_ctl_wk,
  output logic              loop_rst_pulse,
  output logic              align_rst_pulse
);

  localparam logic [FB_W-1:0] FB_RST =
    {rw_reset(3)[FB_W-DATA_W-1:0], rw_reset(2)};

  logic cmd_wr, go_loop, go_align;

  assign cmd_wr   = bus_we && (bus_addr == A_CMD);
  assign go_loop  = cmd_wr && (bus_wdata[DATA_W-1:NIB_W] == CMD_LOOP_NIB);
  assign go_align = cmd_wr && (bus_wdata[NIB_W-1:0] == CMD_ALIGN_NIB);

  always_ff @(posedge clk) begin
    if (rst) begin
      loop_ctl_wk    <= rw_reset(1);
      fb_div_wk      <= FB_RST;
      loop_rst_pulse <= 1'b0;
    end else begin
      loop_rst_pulse <= go_loop;
      if (go_loop) begin
        loop_ctl_wk <= sh_loop;
        fb_div_wk   <= {sh_fb_hi, sh_fb_lo};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      align_ctl_wk    <= rw_reset(5);
      align_rst_pulse <= 1'b0;
    end else begin
      align_rst_pulse <= go_align;
      if (go_align)
        align_ctl_wk <= sh_align;
    end
  end

endmodule

// File: rtl/cfg_read_mux.sv
module cfg_read_mux
  import cfg_regs_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  rw_bank_t          shadow,
  input  logic              aligner_lock,
  input  logic              loop_lock,
  output logic [DATA_W-1:0] rd_data
);

  logic [DATA_W-1:0] rd_next;

  always_comb begin
    rd_next = '0;
    if (bus_addr < ADDR_W'(NUM_RW))
      rd_next = shadow[bus_addr[IDX_W-1:0]];
    else if (bus_addr == A_ID_VER)
      rd_next = ID_VER_VAL;
    else if (bus_addr == A_ID_REV)
      rd_next = ID_REV_VAL;
    else if (bus_addr == A_STATUS)
      rd_next = {{(DATA_W-2){1'b0}}, loop_lock, aligner_lock};
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_next;
  end

endmodule

// File: rtl/cfg_shadow_regs.sv
module cfg_shadow_regs
  import cfg_regs_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  input  logic              aligner_lock,
  input  logic              loop_lock,
  output logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] in_ctrl,
  output logic [DATA_W-1:0] phase_ofs,
  output logic [DATA_W-1:0] out_en,
  output logic [DATA_W-1:0] osc_div,
  output logic [DATA_W-1:0] loop_ctl_wk,
  output logic [FB_W-1:0]   fb_div_wk,
  output logic [DATA_W-1:0] align_ctl_wk,
  output logic              loop_rst_pulse,
  output logic              align_rst_pulse
);

  rw_bank_t shadow;

  cfg_host_regs u_host (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_we    (bus_we),
    .shadow    (shadow)
  );

  cfg_commit u_commit (
    .clk             (clk),
    .rst             (rst),
    .bus_addr        (bus_addr),
    .bus_wdata       (bus_wdata),
    .bus_we          (bus_we),
    .sh_loop         (shadow[1]),
    .sh_fb_lo        (shadow[2]),
    .sh_fb_hi        (shadow[3][FB_W-DATA_W-1:0]),
    .sh_align        (shadow[5]),
    .loop_ctl_wk     (loop_ctl_wk),
    .fb_div_wk       (fb_div_wk),
    .align_ctl_wk    (align_ctl_wk),
    .loop_rst_pulse  (loop_rst_pulse),
    .align_rst_pulse (align_rst_pulse)
  );

  cfg_read_mux u_rd (
    .clk          (clk),
    .rst          (rst),
    .bus_addr     (bus_addr),
    .shadow       (shadow),
    .aligner_lock (aligner_lock),
    .loop_lock    (loop_lock),
    .rd_data      (rd_data)
  );

  assign in_ctrl   = shadow[0];
  assign phase_ofs = shadow[4];
  assign out_en    = shadow[6];
  assign osc_div   = shadow[7];

endmodule

// File: rtl/cfg_shadow_regs_chk.sv
module cfg_shadow_regs_chk
  import cfg_regs_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              bus_we,
  input logic [DATA_W-1:0] rd_data,
  input logic [DATA_W-1:0] in_ctrl,
  input logic [DATA_W-1:0] loop_ctl_wk,
  input logic [FB_W-1:0]   fb_div_wk,
  input logic [DATA_W-1:0] align_ctl_wk,
  input logic              loop_rst_pulse,
  input logic              align_rst_pulse
);

  AST_LOOP_PULSE_CAUSE: assert property (@(posedge clk) disable iff (rst)
    loop_rst_pulse |-> ($past(bus_we) && $past(bus_addr) == A_CMD &&
                        $past(bus_wdata[DATA_W-1:NIB_W]) == CMD_LOOP_NIB)); // R5

  AST_ALIGN_PULSE_CAUSE: assert property (@(posedge clk) disable iff (rst)
    align_rst_pulse |-> ($past(bus_we) && $past(bus_addr) == A_CMD &&
                         $past(bus_wdata[NIB_W-1:0]) == CMD_ALIGN_NIB)); // R6

  AST_LOOP_WK_HOLD: assert property (@(posedge clk) disable iff (rst)
    !loop_rst_pulse |-> ($stable(loop_ctl_wk) && $stable(fb_div_wk))); // R4

  AST_ALIGN_WK_HOLD: assert property (@(posedge clk) disable iff (rst)
    !align_rst_pulse |-> $stable(align_ctl_wk)); // R4

  AST_ID_VER_READ: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(bus_addr) == A_ID_VER) |-> rd_data == ID_VER_VAL); // R8

  AST_STATUS_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(bus_addr) == A_STATUS) |-> rd_data[DATA_W-1:2] == '0); // R9

  AST_DIRECT_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(bus_we) && $past(bus_addr) == ADDR_W'(0))
      |-> in_ctrl == $past(bus_wdata)); // R3

endmodule

bind cfg_shadow_regs cfg_shadow_regs_chk u_chk (
  .clk             (clk),
  .rst             (rst),
  .bus_addr        (bus_addr),
  .bus_wdata       (bus_wdata),
  .bus_we          (bus_we),
  .rd_data         (rd_data),
  .in_ctrl         (in_ctrl),
  .loop_ctl_wk     (loop_ctl_wk),
  .fb_div_wk       (fb_div_wk),
  .align_ctl_wk    (align_ctl_wk),
  .loop_rst_pulse  (loop_rst_pulse),
  .align_rst_pulse (align_rst_pulse)
);

// File: tb/tb_cfg_shadow_regs.sv
module tb_cfg_shadow_regs;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [4:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic       bus_we = 1'b0;
  logic       aligner_lock = 1'b0;
  logic       loop_lock = 1'b0;
  logic [7:0]  rd_data, in_ctrl, phase_ofs, out_en, osc_div, loop_ctl_wk, align_ctl_wk;
  logic [11:0] fb_div_wk;
  logic        loop_rst_pulse, align_rst_pulse;

  cfg_shadow_regs dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .aligner_lock(aligner_lock), .loop_lock(loop_lock),
    .rd_data(rd_data), .in_ctrl(in_ctrl), .phase_ofs(phase_ofs),
    .out_en(out_en), .osc_div(osc_div), .loop_ctl_wk(loop_ctl_wk),
    .fb_div_wk(fb_div_wk), .align_ctl_wk(align_ctl_wk),
    .loop_rst_pulse(loop_rst_pulse), .align_rst_pulse(align_rst_pulse)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_vec = 0;
  int n_bad = 0;
  bit finished = 0;
  string phase = "R1";

  // Reference model state
  int m_sh[8];
  int m_wk1, m_wk2, m_wk3, m_wk5;
  int m_rd;
  bit m_lp, m_ap;

  function automatic int keep_of(int i);
    if (i == 1) return 'h37;
    if (i == 3) return 'h0F;
    if (i == 4) return 'hBF;
    return 'hFF;
  endfunction

  function automatic void model_reset();
    m_sh[0] = 'h41; m_sh[1] = 'h00; m_sh[2] = 'hFF; m_sh[3] = 'h0F;
    m_sh[4] = 'h80; m_sh[5] = 'h03; m_sh[6] = 'h1F; m_sh[7] = 'h80;
    m_wk1 = 'h00; m_wk2 = 'hFF; m_wk3 = 'h0F; m_wk5 = 'h03;
    m_rd = 0; m_lp = 0; m_ap = 0;
  endfunction

  function automatic int model_read(int a, bit al, bit ll);
    if (a < 8) return m_sh[a];
    if (a == 'h10) return 'h18;
    if (a == 'h11) return 'h01;
    if (a == 'h12) return (int'(ll) << 1) | int'(al);
    return 0;
  endfunction

  function automatic string rd_tag(int a);
    if (phase == "R1") return "R1";
    if (a < 8) return "R2";
    if (a == 'h10 || a == 'h11 || a == 8) return "R8";
    if (a == 'h12) return "R9";
    return "R10";
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s [%s] %s actual=0x%0h expected=0x%0h t=%0t",
               tag, phase, what, act, exp, $time);
    end
  endtask

  task automatic compare_all(int a);
    string t3;
    t3 = (phase == "R1") ? "R1" : "R3";
    chk(rd_tag(a), "rd_data (R11 latency)", int'(rd_data), m_rd);
    chk(t3, "in_ctrl",   int'(in_ctrl),   m_sh[0]);
    chk(t3, "phase_ofs", int'(phase_ofs), m_sh[4]);
    chk(t3, "out_en",    int'(out_en),    m_sh[6]);
    chk(t3, "osc_div",   int'(osc_div),   m_sh[7]);
    chk("R4", "loop_ctl_wk",  int'(loop_ctl_wk),  m_wk1);
    chk("R12", "fb_div_wk",   int'(fb_div_wk),    ((m_wk3 & 'hF) << 8) | m_wk2);
    chk("R4", "align_ctl_wk", int'(align_ctl_wk), m_wk5);
    chk("R5", "loop_rst_pulse",  int'(loop_rst_pulse),  int'(m_lp));
    chk("R6", "align_rst_pulse", int'(align_rst_pulse), int'(m_ap));
  endtask

  // one bus cycle: drive at negedge, model at posedge, compare at next negedge
  task automatic cyc(int a, int d, bit we, bit al, bit ll);
    bus_addr = 5'(a); bus_wdata = 8'(d); bus_we = we;
    aligner_lock = al; loop_lock = ll;
    @(posedge clk);
    if (rst) model_reset();
    else begin
      m_rd = model_read(a, al, ll);
      m_lp = we && a == 8 && ((d >> 4) & 'hF) == 5;
      m_ap = we && a == 8 && (d & 'hF) == 'hA;
      if (m_lp) begin m_wk1 = m_sh[1]; m_wk2 = m_sh[2]; m_wk3 = m_sh[3]; end
      if (m_ap) m_wk5 = m_sh[5];
      if (we && a < 8) m_sh[a] = d & keep_of(a);
    end
    @(negedge clk);
    compare_all(a);
  endtask

  task automatic wr(int a, int d); cyc(a, d, 1, aligner_lock, loop_lock); endtask
  task automatic rd(int a);        cyc(a, 0, 0, aligner_lock, loop_lock); endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin : stim
    int lf;
    model_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) cyc(0, 0, 0, 0, 0);
    rst = 1'b0;
    // R1: reset contents
    phase = "R1";
    for (int i = 0; i < 8; i++) rd(i);
    rd(0);
    // R2/R3: program every writable register with all ones, then distinct values
    phase = "R2";
    for (int i = 0; i < 8; i++) wr(i, 'hFF);
    for (int i = 0; i < 8; i++) rd(i);
    for (int i = 0; i < 8; i++) wr(i, 'hA0 + i * 3);
    for (int i = 0; i < 8; i++) rd(i);
    // R4: working copies must still hold reset values here (checked each cycle)
    phase = "R4";
    wr(1, 'h26); wr(2, 'h9C); wr(3, 'hF7); wr(5, 'h41);
    rd(0); rd(0);
    // R5: loop commit only
    phase = "R5";
    wr(8, 'h50); rd(0); rd(0);
    // R6: aligner commit only, then both
    phase = "R6";
    wr(8, 'h0A); rd(0);
    wr(1, 'h11); wr(2, 'h22); wr(3, 'h03); wr(5, 'hC2);
    wr(8, 'h5A); rd(0);
    // R7: non-matching command bytes, incl. swapped nibbles
    phase = "R7";
    wr(1, 'h35); wr(5, 'h7E);
    wr(8, 'hA5); rd(8); wr(8, 'h00); wr(8, 'h4B); wr(8, 'hFF); rd(0);
    // back-to-back commands: pulse stays high two cycles
    phase = "R5";
    wr(8, 'h55); wr(8, 'h5A); rd(0);
    // R8/R9: identification and status
    phase = "R8";
    rd('h10); rd('h11); rd(8);
    phase = "R9";
    cyc('h12, 0, 0, 0, 0); cyc('h12, 0, 0, 1, 0);
    cyc('h12, 0, 0, 0, 1); cyc('h12, 0, 0, 1, 1);
    // R10: unmapped reads, ignored writes
    phase = "R10";
    rd('h09); rd('h0F); rd('h13); rd('h1F);
    wr('h10, 'h00); wr('h11, 'hFF); wr('h12, 'hFF); wr('h1F, 'h55); wr('h0C, 'h5A);
    rd('h10); rd('h11); for (int i = 0; i < 8; i++) rd(i);
    // R11 and mixed traffic
    phase = "R11";
    lf = 'hACE1;
    for (int k = 0; k < 400; k++) begin
      int a, d;
      lf = ((lf >> 1) ^ ((lf & 1) ? 'hB400 : 0)) & 'hFFFF;
      a = lf % 24;
      d = (lf >> 5) & 'hFF;
      if ((lf & 'h7) == 0) begin a = 8; d = ((lf >> 3) & 3) == 0 ? 'h5A :
                                        ((lf >> 3) & 3) == 1 ? 'h50 :
                                        ((lf >> 3) & 3) == 2 ? 'h0A : 'hA5; end
      cyc(a, d, (lf >> 13) & 1, (lf >> 14) & 1, (lf >> 15) & 1);
    end
    // reset again mid-run
    phase = "R1";
    rst = 1'b1; cyc(0, 0, 0, 0, 0); cyc(0, 0, 0, 0, 0); rst = 1'b0;
    for (int i = 0; i < 8; i++) rd(i);
    rd(0);
    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule